// File: doc/BRIEF.md
# Macro-Op Fusion Pair Detector

This block sits beside an RV64 decode stage and looks at two adjacent 32-bit instruction words, each qualified by its own valid bit. It decides whether the older and younger instruction together form one of a fixed catalogue of fusible pairs. On a match it raises a fuse flag and reports a 5-bit fused-operation code naming the pattern, so that later stages can treat the pair as one operation.

Each word is decoded into instruction classes, shift amounts and I-type immediates from the standard RV64I and Zbb encodings. The pair matcher then tests the catalogue against those classes. A separate check enforces the tied-register rule: the younger instruction must overwrite the older one's destination and read it back as its first source. The verdict is registered, so the result for the words present at one rising edge appears on the outputs just after that edge.

Top module: `macro_fuse_detect`

## Requirements
- R1: A synchronous active-high reset clears the fuse flag and sets the code to 0. Outside reset, the outputs after a rising edge give the verdict for the inputs sampled at that edge.
- R2: No fusion is reported when either slot's valid bit is low.
- R3: A pair fuses only if three conditions hold together. The younger rd (bits 11:7) equals the older rd. The younger rs1 (bits 19:15) equals that rd. That rd is not x0. A younger rs2 that matches the rd does not satisfy the rule.
- R4: LUI followed by ADDI or ADDIW gives code 1.
- R5: Four shift pairs need equal shift amounts on both words. SLLI 32 then SRLI 32 gives code 2, and SLLI 48 then SRLI 48 gives code 3. SLLIW 16 then SRLIW 16 gives code 4, and SLLIW 16 then SRAIW 16 gives code 5. Any other combination of shift amounts does not fuse. Shift amounts are the raw shamt field.
- R6: Shift-then-ADD pairs each have their own code. SLLI by 1, 2 or 3 then ADD gives code 6, and SLLI by 4 then ADD gives code 7. SRLI by 29, 30, 31 or 32 then ADD gives code 10. SRAI and other shift amounts do not fuse.
- R7: SLLI 32 then SRLI 29, 30 or 31 gives code 8. SRLI 8 then ANDI with immediate 255 gives code 9.
- R8: ANDI with immediate 1 then ADD or ADDW gives code 11. ADDW then ANDI with immediate 1 or 255 gives code 12. Immediates are the raw 12-bit I-type field. ADDW then ZEXT.H or SEXT.H gives code 13. ZEXT.H is the word with bits 31:25 = 0000100, rs2 = 0, funct3 100 and opcode 0111011. SEXT.H is the word with imm 0x605, funct3 001 and opcode 0010011.
- R9: A logic operation then ANDI with immediate 1 gives code 14. The same logic operation then ZEXT.H gives code 15. The logic operation is AND, OR, XOR, ANDI, ORI, XORI or ORC.B, where ORC.B is the word with imm 0x287, funct3 101 and opcode 0010011.
- R10: The fuse flag is high exactly when the code is nonzero. At most one pattern matches a pair. Every pair outside the catalogue, such as SUB or SRAI pairs, gives code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| slot0_valid | input | 1 | Older instruction word is valid |
| slot0_insn | input | 32 | Older instruction word |
| slot1_valid | input | 1 | Younger instruction word is valid |
| slot1_insn | input | 32 | Younger instruction word |
| fuse_o | output | 1 | Registered fuse verdict |
| fuse_op_o | output | 5 | Registered fused-operation code, 0 when no fusion |

## Verification
The assertions assume that reset is asserted at the start and that both instruction buses carry known values whenever the valid bits are sampled. The single-match check also relies on the words being legal encodings. The stimulus keeps to this by building every word from a legal class with a shift amount that fits its field. The sweep pairs every class and immediate choice on both slots, using tied registers. Separate directed pairs then break the register rule, drop a valid bit or assert reset on a fusing pair.

// File: rtl/mfuse_pkg.sv
package mfuse_pkg;

   localparam int unsigned FOP_W     = 5;
   localparam int unsigned FOP_COUNT = 15;

   typedef enum logic [FOP_W-1:0] {
      FOP_NONE        = 5'd0,
      FOP_LUI_ADD     = 5'd1,
      FOP_ZEXT_W      = 5'd2,
      FOP_ZEXT_LO16   = 5'd3,
      FOP_ZEXTW_LO16  = 5'd4,
      FOP_SEXTW_LO16  = 5'd5,
      FOP_SHL_ADD     = 5'd6,
      FOP_SHL4_ADD    = 5'd7,
      FOP_ZEXT_SHL    = 5'd8,
      FOP_BYTE1       = 5'd9,
      FOP_SHR_ADD     = 5'd10,
      FOP_ODD_ADD     = 5'd11,
      FOP_ADDW_MASK   = 5'd12,
      FOP_ADDW_EXT16  = 5'd13,
      FOP_LOGIC_BIT0  = 5'd14,
      FOP_LOGIC_LO16  = 5'd15
   } fop_e;

   // major opcodes
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_OPIMMW = 7'b0011011;
   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_OPW    = 7'b0111011;

   // fixed immediate fields of single-operand bit-manipulation ops
   localparam logic [11:0] IMM_SEXTH = 12'h605;
   localparam logic [11:0] IMM_ORCB  = 12'h287;
   localparam logic [6:0]  F7_ZEXTH  = 7'b0000100;

   typedef struct packed {
      logic        is_lui;
      logic        is_addi;
      logic        is_addiw;
      logic        is_slli;
      logic        is_srli;
      logic        is_slliw;
      logic        is_srliw;
      logic        is_sraiw;
      logic        is_add;
      logic        is_addw;
      logic        is_andi;
      logic        is_logic;
      logic        is_zexth;
      logic        is_sexth;
      logic [5:0]  shamt;
      logic [11:0] imm;
      logic [4:0]  rd;
      logic [4:0]  rs1;
   } insn_cls_t;

endpackage

// File: rtl/fuse_slot_decode.sv
module fuse_slot_decode
   import mfuse_pkg::*;
#(
   parameter int unsigned ILEN = 32,
   parameter int unsigned REGW = 5
) (
   input  logic [ILEN-1:0] insn,
   output insn_cls_t       cls
);

   localparam int unsigned RD_LO  = 7;
   localparam int unsigned RS1_LO = 15;
   localparam int unsigned F3_LO  = 12;

   if (ILEN != 32) begin : g_bad_ilen
      $error("fuse_slot_decode: ILEN must be 32");
   end
   if (REGW != 5) begin : g_bad_regw
      $error("fuse_slot_decode: REGW must be 5");
   end

   logic [6:0]      opc;
   logic [2:0]      f3;
   logic [6:0]      f7;
   logic [5:0]      f6;
   logic [REGW-1:0] rs2;

   always_comb begin
      opc = insn[6:0];
      f3  = insn[F3_LO +: 3];
      f7  = insn[31:25];
      f6  = insn[31:26];
      rs2 = insn[24:20];

      cls          = '0;
      cls.rd       = insn[RD_LO +: REGW];
      cls.rs1      = insn[RS1_LO +: REGW];
      cls.imm      = insn[31:20];
      cls.shamt    = insn[25:20];

      cls.is_lui   = (opc == OPC_LUI);
      cls.is_addi  = (opc == OPC_OPIMM)  && (f3 == 3'b000);
      cls.is_addiw = (opc == OPC_OPIMMW) && (f3 == 3'b000);
      cls.is_slli  = (opc == OPC_OPIMM)  && (f3 == 3'b001) && (f6 == 6'b000000);
      cls.is_srli  = (opc == OPC_OPIMM)  && (f3 == 3'b101) && (f6 == 6'b000000);
      cls.is_slliw = (opc == OPC_OPIMMW) && (f3 == 3'b001) && (f7 == 7'b0000000);
      cls.is_srliw = (opc == OPC_OPIMMW) && (f3 == 3'b101) && (f7 == 7'b0000000);
      cls.is_sraiw = (opc == OPC_OPIMMW) && (f3 == 3'b101) && (f7 == 7'b0100000);
      cls.is_add   = (opc == OPC_OP)     && (f3 == 3'b000) && (f7 == 7'b0000000);
      cls.is_addw  = (opc == OPC_OPW)    && (f3 == 3'b000) && (f7 == 7'b0000000);
      cls.is_andi  = (opc == OPC_OPIMM)  && (f3 == 3'b111);
      cls.is_zexth = (opc == OPC_OPW)    && (f3 == 3'b100) && (f7 == F7_ZEXTH)
                     && (rs2 == '0);
      cls.is_sexth = (opc == OPC_OPIMM)  && (f3 == 3'b001) && (insn[31:20] == IMM_SEXTH);

      cls.is_logic = cls.is_andi
                   || ((opc == OPC_OPIMM) && (f3 == 3'b110))
                   || ((opc == OPC_OPIMM) && (f3 == 3'b100))
                   || ((opc == OPC_OP) && (f7 == 7'b0000000)
                       && ((f3 == 3'b111) || (f3 == 3'b110) || (f3 == 3'b100)))
                   || ((opc == OPC_OPIMM) && (f3 == 3'b101) && (insn[31:20] == IMM_ORCB));
   end

endmodule

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
   import mfuse_pkg::*;
#(
   parameter int unsigned NPAT = FOP_COUNT
) (
   input  insn_cls_t        older,
   input  insn_cls_t        younger,
   output logic [NPAT-1:0]  hit,
   output logic             tie_ok
);

   if (NPAT != FOP_COUNT) begin : g_bad_npat
      $error("fuse_pair_match: NPAT must equal the catalogue size");
   end

   localparam logic [11:0] IMM_ONE  = 12'h001;
   localparam logic [11:0] IMM_BYTE = 12'h0FF;

   logic sh_small, sh_hi, sh_zx;

   always_comb begin
      sh_small = (older.shamt >= 6'd1)  && (older.shamt <= 6'd3);
      sh_hi    = (older.shamt >= 6'd29) && (older.shamt <= 6'd32);
      sh_zx    = (younger.shamt >= 6'd29) && (younger.shamt <= 6'd31);

      hit = '0;
      hit[int'(FOP_LUI_ADD)-1]    = older.is_lui && (younger.is_addi || younger.is_addiw);
      hit[int'(FOP_ZEXT_W)-1]     = older.is_slli && (older.shamt == 6'd32)
                                    && younger.is_srli && (younger.shamt == 6'd32);
      hit[int'(FOP_ZEXT_LO16)-1]  = older.is_slli && (older.shamt == 6'd48)
                                    && younger.is_srli && (younger.shamt == 6'd48);
      hit[int'(FOP_ZEXTW_LO16)-1] = older.is_slliw && (older.shamt == 6'd16)
                                    && younger.is_srliw && (younger.shamt == 6'd16);
      hit[int'(FOP_SEXTW_LO16)-1] = older.is_slliw && (older.shamt == 6'd16)
                                    && younger.is_sraiw && (younger.shamt == 6'd16);
      hit[int'(FOP_SHL_ADD)-1]    = older.is_slli && sh_small && younger.is_add;
      hit[int'(FOP_SHL4_ADD)-1]   = older.is_slli && (older.shamt == 6'd4) && younger.is_add;
      hit[int'(FOP_ZEXT_SHL)-1]   = older.is_slli && (older.shamt == 6'd32)
                                    && younger.is_srli && sh_zx;
      hit[int'(FOP_BYTE1)-1]      = older.is_srli && (older.shamt == 6'd8)
                                    && younger.is_andi && (younger.imm == IMM_BYTE);
      hit[int'(FOP_SHR_ADD)-1]    = older.is_srli && sh_hi && younger.is_add;
      hit[int'(FOP_ODD_ADD)-1]    = older.is_andi && (older.imm == IMM_ONE)
                                    && (younger.is_add || younger.is_addw);
      hit[int'(FOP_ADDW_MASK)-1]  = older.is_addw && younger.is_andi
                                    && ((younger.imm == IMM_ONE) || (younger.imm == IMM_BYTE));
      hit[int'(FOP_ADDW_EXT16)-1] = older.is_addw && (younger.is_zexth || younger.is_sexth);
      hit[int'(FOP_LOGIC_BIT0)-1] = older.is_logic && younger.is_andi
                                    && (younger.imm == IMM_ONE);
      hit[int'(FOP_LOGIC_LO16)-1] = older.is_logic && younger.is_zexth;

      tie_ok = (younger.rd == older.rd) && (younger.rs1 == older.rd) && (older.rd != '0);
   end

endmodule

// File: rtl/fuse_code_encode.sv
module fuse_code_encode #(
   parameter int unsigned NPAT = 15,
   parameter int unsigned OPW  = 5
) (
   input  logic [NPAT-1:0] hit,
   output logic [OPW-1:0]  code
);

   if (NPAT >= (1 << OPW)) begin : g_bad_width
      $error("fuse_code_encode: OPW too narrow for NPAT codes");
   end

   logic [OPW-1:0] term [NPAT];

   for (genvar gi = 0; gi < NPAT; gi++) begin : g_term
      assign term[gi] = hit[gi] ? OPW'(gi + 1) : '0;
   end

   always_comb begin
      code = '0;
      for (int i = 0; i < NPAT; i++) begin
         code = code | term[i];
      end
   end

endmodule

// File: rtl/macro_fuse_detect.sv
module macro_fuse_detect
   import mfuse_pkg::*;
#(
   parameter int unsigned ILEN = 32,
   parameter int unsigned REGW = 5,
   parameter int unsigned OPW  = FOP_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            slot0_valid,
   input  logic [ILEN-1:0] slot0_insn,
   input  logic            slot1_valid,
   input  logic [ILEN-1:0] slot1_insn,
   output logic            fuse_o,
   output logic [OPW-1:0]  fuse_op_o
);

   localparam int unsigned NSLOT = 2;
   localparam int unsigned NPAT  = FOP_COUNT;

   if (OPW != FOP_W) begin : g_bad_opw
      $error("macro_fuse_detect: OPW must match the code enum width");
   end

   logic [ILEN-1:0] slot_insn [NSLOT];
   insn_cls_t       slot_cls  [NSLOT];

   assign slot_insn[0] = slot0_insn;
   assign slot_insn[1] = slot1_insn;

   for (genvar gs = 0; gs < NSLOT; gs++) begin : g_slot
      fuse_slot_decode #(
         .ILEN (ILEN),
         .REGW (REGW)
      ) u_dec (
         .insn (slot_insn[gs]),
         .cls  (slot_cls[gs])
      );
   end

   logic [NPAT-1:0] hit;
   logic            tie_ok;
   logic [OPW-1:0]  code;
   logic            fire;

   fuse_pair_match #(
      .NPAT (NPAT)
   ) u_match (
      .older   (slot_cls[0]),
      .younger (slot_cls[1]),
      .hit     (hit),
      .tie_ok  (tie_ok)
   );

   fuse_code_encode #(
      .NPAT (NPAT),
      .OPW  (OPW)
   ) u_enc (
      .hit  (hit),
      .code (code)
   );

   assign fire = slot0_valid && slot1_valid && tie_ok && (|hit);

   always_ff @(posedge clk) begin
      if (rst) begin
         fuse_o    <= 1'b0;
         fuse_op_o <= '0;
      end else begin
         fuse_o    <= fire;
         fuse_op_o <= fire ? code : '0;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!fuse_o && (fuse_op_o == '0)));

   assert_no_fuse_invalid_R2: assert property (@(posedge clk) disable iff (rst)
      !(slot0_valid && slot1_valid) |=> !fuse_o);

   assert_tie_rule_R3: assert property (@(posedge clk) disable iff (rst)
      !tie_ok |=> !fuse_o);

   assert_flag_matches_code_R10: assert property (@(posedge clk) disable iff (rst)
      fuse_o == (fuse_op_o != '0));

   assert_single_pattern_R10: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit));

endmodule

// File: tb/macro_fuse_detect_tb.sv
module macro_fuse_detect_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        v0 = 1'b0, v1 = 1'b0;
   logic [31:0] i0 = '0, i1 = '0;
   logic        fuse;
   logic [4:0]  op;

   int nrun  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   macro_fuse_detect u_dut (
      .clk         (clk),
      .rst         (rst),
      .slot0_valid (v0),
      .slot0_insn  (i0),
      .slot1_valid (v1),
      .slot1_insn  (i1),
      .fuse_o      (fuse),
      .fuse_op_o   (op)
   );

   // instruction kinds
   localparam int K_LUI = 0,  K_ADDI = 1,  K_ADDIW = 2,  K_SLLI = 3,  K_SRLI = 4;
   localparam int K_SRAI = 5, K_SLLIW = 6, K_SRLIW = 7,  K_SRAIW = 8, K_ADD = 9;
   localparam int K_ADDW = 10, K_ANDI = 11, K_ORI = 12,  K_XORI = 13, K_AND = 14;
   localparam int K_OR = 15,  K_XOR = 16,  K_ZEXTH = 17, K_SEXTH = 18, K_ORCB = 19;
   localparam int K_SUB = 20;
   localparam int NK = 21;

   function automatic int sh_at(int j);
      case (j)
         0: return 0;   1: return 1;   2: return 2;   3: return 3;
         4: return 4;   5: return 5;   6: return 8;   7: return 16;
         8: return 29;  9: return 30;  10: return 31; 11: return 32;
         12: return 33; default: return 48;
      endcase
   endfunction

   function automatic int imm_at(int j);
      case (j)
         0: return 1; 1: return 255; 2: return 0; 3: return 2; default: return 12'hFFF;
      endcase
   endfunction

   function automatic bit is_sh64(int k);
      return (k == K_SLLI) || (k == K_SRLI) || (k == K_SRAI);
   endfunction
   function automatic bit is_sh32(int k);
      return (k == K_SLLIW) || (k == K_SRLIW) || (k == K_SRAIW);
   endfunction
   function automatic bit is_ityp(int k);
      return (k == K_ADDI) || (k == K_ADDIW) || (k == K_ANDI) || (k == K_ORI) || (k == K_XORI);
   endfunction

   function automatic bit var_ok(int k, int j);
      if (is_sh64(k)) return 1'b1;
      if (is_sh32(k)) return (sh_at(j) < 32);
      if (is_ityp(k)) return (j < 5);
      return (j == 0);
   endfunction

   function automatic int var_val(int k, int j);
      if (is_sh64(k) || is_sh32(k)) return sh_at(j);
      if (is_ityp(k)) return imm_at(j);
      return 0;
   endfunction

   function automatic logic [31:0] enc(int k, int v, logic [4:0] rd, logic [4:0] rs1,
                                       logic [4:0] rs2);
      logic [11:0] im;
      im = v[11:0];
      case (k)
         K_LUI:   return {20'h12345, rd, 7'h37};
         K_ADDI:  return {im, rs1, 3'b000, rd, 7'h13};
         K_ADDIW: return {im, rs1, 3'b000, rd, 7'h1B};
         K_SLLI:  return {6'b000000, v[5:0], rs1, 3'b001, rd, 7'h13};
         K_SRLI:  return {6'b000000, v[5:0], rs1, 3'b101, rd, 7'h13};
         K_SRAI:  return {6'b010000, v[5:0], rs1, 3'b101, rd, 7'h13};
         K_SLLIW: return {7'b0000000, v[4:0], rs1, 3'b001, rd, 7'h1B};
         K_SRLIW: return {7'b0000000, v[4:0], rs1, 3'b101, rd, 7'h1B};
         K_SRAIW: return {7'b0100000, v[4:0], rs1, 3'b101, rd, 7'h1B};
         K_ADD:   return {7'b0000000, rs2, rs1, 3'b000, rd, 7'h33};
         K_SUB:   return {7'b0100000, rs2, rs1, 3'b000, rd, 7'h33};
         K_ADDW:  return {7'b0000000, rs2, rs1, 3'b000, rd, 7'h3B};
         K_ANDI:  return {im, rs1, 3'b111, rd, 7'h13};
         K_ORI:   return {im, rs1, 3'b110, rd, 7'h13};
         K_XORI:  return {im, rs1, 3'b100, rd, 7'h13};
         K_AND:   return {7'b0000000, rs2, rs1, 3'b111, rd, 7'h33};
         K_OR:    return {7'b0000000, rs2, rs1, 3'b110, rd, 7'h33};
         K_XOR:   return {7'b0000000, rs2, rs1, 3'b100, rd, 7'h33};
         K_ZEXTH: return {7'b0000100, 5'd0, rs1, 3'b100, rd, 7'h3B};
         K_SEXTH: return {12'h605, rs1, 3'b001, rd, 7'h13};
         default: return {12'h287, rs1, 3'b101, rd, 7'h13};
      endcase
   endfunction

   function automatic bit is_logic(int k);
      return (k == K_AND) || (k == K_OR) || (k == K_XOR) || (k == K_ANDI) ||
             (k == K_ORI) || (k == K_XORI) || (k == K_ORCB);
   endfunction

   // expected code for a tied, valid pair (R4..R10)
   function automatic int exp_code(int k0, int a, int k1, int b);
      if (k0 == K_LUI && (k1 == K_ADDI || k1 == K_ADDIW)) return 1;
      if (k0 == K_SLLI && a == 32 && k1 == K_SRLI && b == 32) return 2;
      if (k0 == K_SLLI && a == 48 && k1 == K_SRLI && b == 48) return 3;
      if (k0 == K_SLLIW && a == 16 && k1 == K_SRLIW && b == 16) return 4;
      if (k0 == K_SLLIW && a == 16 && k1 == K_SRAIW && b == 16) return 5;
      if (k0 == K_SLLI && a >= 1 && a <= 3 && k1 == K_ADD) return 6;
      if (k0 == K_SLLI && a == 4 && k1 == K_ADD) return 7;
      if (k0 == K_SLLI && a == 32 && k1 == K_SRLI && b >= 29 && b <= 31) return 8;
      if (k0 == K_SRLI && a == 8 && k1 == K_ANDI && b == 255) return 9;
      if (k0 == K_SRLI && a >= 29 && a <= 32 && k1 == K_ADD) return 10;
      if (k0 == K_ANDI && a == 1 && (k1 == K_ADD || k1 == K_ADDW)) return 11;
      if (k0 == K_ADDW && k1 == K_ANDI && (b == 1 || b == 255)) return 12;
      if (k0 == K_ADDW && (k1 == K_ZEXTH || k1 == K_SEXTH)) return 13;
      if (is_logic(k0) && k1 == K_ANDI && b == 1) return 14;
      if (is_logic(k0) && k1 == K_ZEXTH) return 15;
      return 0;
   endfunction

   function automatic string req_of(int c);
      case (c)
         0: return "R10";
         1: return "R4";
         2, 3, 4, 5: return "R5";
         6, 7, 10: return "R6";
         8, 9: return "R7";
         11, 12, 13: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(string req, int exp_c);
      nrun++;
      if (fuse !== (exp_c != 0) || op !== 5'(exp_c)) begin
         nfail++;
         $display("FAIL %s: fuse=%0b code=%0d expected fuse=%0b code=%0d (i0=%h i1=%h)",
                  req, fuse, op, (exp_c != 0), exp_c, i0, i1);
      end
   endtask

   task automatic apply(logic a_v, logic [31:0] a_i, logic b_v, logic [31:0] b_i);
      @(negedge clk);
      v0 = a_v; i0 = a_i; v1 = b_v; i1 = b_i;
      @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         nrun++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", nrun, nfail);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] pa, pb;
      // R1: reset state with a fusing pair on the inputs
      pa = enc(K_SLLI, 2, 5'd7, 5'd3, 5'd9);
      pb = enc(K_ADD, 0, 5'd7, 5'd7, 5'd11);
      rst = 1'b1;
      apply(1'b1, pa, 1'b1, pb);
      check("R1", 0);
      apply(1'b1, pa, 1'b1, pb);
      check("R1", 0);
      rst = 1'b0;
      // R1: first verdict after release, one edge of latency
      apply(1'b1, pa, 1'b1, pb);
      check("R1", 6);

      // R4..R10: sweep of tied pairs
      for (int k0 = 0; k0 < NK; k0++) begin
         for (int j0 = 0; j0 < 14; j0++) begin
            if (!var_ok(k0, j0)) continue;
            for (int k1 = 0; k1 < NK; k1++) begin
               for (int j1 = 0; j1 < 14; j1++) begin
                  int a, b, e;
                  if (!var_ok(k1, j1)) continue;
                  a = var_val(k0, j0);
                  b = var_val(k1, j1);
                  e = exp_code(k0, a, k1, b);
                  apply(1'b1, enc(k0, a, 5'd7, 5'd3, 5'd9),
                        1'b1, enc(k1, b, 5'd7, 5'd7, 5'd11));
                  check(req_of(e), e);
               end
            end
         end
      end

      // R3: tied-register rule
      pa = enc(K_SLLI, 32, 5'd31, 5'd4, 5'd0);
      apply(1'b1, pa, 1'b1, enc(K_SRLI, 32, 5'd31, 5'd31, 5'd0));
      check("R3", 2);
      apply(1'b1, pa, 1'b1, enc(K_SRLI, 32, 5'd30, 5'd31, 5'd0));
      check("R3", 0);
      apply(1'b1, pa, 1'b1, enc(K_SRLI, 32, 5'd31, 5'd4, 5'd0));
      check("R3", 0);
      pa = enc(K_SLLI, 32, 5'd0, 5'd4, 5'd0);
      apply(1'b1, pa, 1'b1, enc(K_SRLI, 32, 5'd0, 5'd0, 5'd0));
      check("R3", 0);
      pa = enc(K_ANDI, 1, 5'd12, 5'd2, 5'd0);
      apply(1'b1, pa, 1'b1, enc(K_ADD, 0, 5'd12, 5'd6, 5'd12));
      check("R3", 0);
      apply(1'b1, pa, 1'b1, enc(K_ADDW, 0, 5'd12, 5'd12, 5'd6));
      check("R3", 11);

      // R2: valid qualification
      pa = enc(K_LUI, 0, 5'd9, 5'd0, 5'd0);
      pb = enc(K_ADDIW, 12'h7FF, 5'd9, 5'd9, 5'd0);
      apply(1'b0, pa, 1'b1, pb);
      check("R2", 0);
      apply(1'b1, pa, 1'b0, pb);
      check("R2", 0);
      apply(1'b0, pa, 1'b0, pb);
      check("R2", 0);
      apply(1'b1, pa, 1'b1, pb);
      check("R2", 1);

      // R1: reset mid-run on a fusing pair clears the outputs
      rst = 1'b1;
      apply(1'b1, pa, 1'b1, pb);
      check("R1", 0);
      rst = 1'b0;
      apply(1'b1, pa, 1'b1, pb);
      check("R1", 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
   end

endmodule